// File: doc/BRIEF.md
# Integer Compare and Predicate Unit

A combinational datapath block that compares two 32-bit integers and turns the outcome into either a pair of predicate bits or a selected data word. The compare operation comes from a 3-bit code; a signedness bit picks two's-complement or unsigned ordering.

In predicate mode the block compares `src_a` against `src_b`. The outcome is merged with an incoming predicate by AND, OR or XOR, and drives `pred_out0`. The inverted outcome is merged with the same predicate by the same operation, and drives `pred_out1`. In select mode the block compares `src_c` against zero. It passes `src_a` to `sel_out` when the relation holds and `src_b` when it does not. There is no clock and no stored state. Predicate storage belongs to the surrounding pipeline.

The control flow reduces to two named modes. MODE_PRED is taken when `mode_sel` = 0 and MODE_SEL when `mode_sel` = 1. The mode changes only with the input: MODE_PRED goes to MODE_SEL on `mode_sel` 0→1, and MODE_SEL goes back to MODE_PRED on 1→0. Nothing is held between evaluations.

Top module: `icp_unit`

## Requirements
- R1: With `is_signed` = 1, the compare codes are evaluated on two's-complement values: 1 = less, 2 = equal, 3 = less-or-equal, 4 = greater, 5 = not-equal, 6 = greater-or-equal. The test in predicate mode is `src_a` op `src_b`.
- R2: With `is_signed` = 0, the same codes use unsigned ordering. For example, 0x80000000 is greater than 0x7FFFFFFF.
- R3: In predicate mode, `pred_out0` = outcome combined with `pred_in` using `logic_code` (0 = AND, 1 = OR, 2 = XOR).
- R4: In predicate mode, `pred_out1` = (NOT outcome) combined with `pred_in` by the same `logic_code` operation.
- R5: Compare codes 0 and 7 set `invalid` = 1 in either mode, and both predicate outputs are 0.
- R6: In predicate mode, `logic_code` = 3 sets `invalid` = 1 and both predicate outputs are 0.
- R7: In select mode (`mode_sel` = 1), `sel_out` = `src_a` when (`src_c` op 0) holds and `src_b` otherwise. Both predicate outputs are 0.
- R8: In select mode, `src_c` is compared as signed when `is_signed` = 1 and as unsigned when `is_signed` = 0.
- R9: In predicate mode `sel_out` is 0. In select mode `logic_code` and `pred_in` have no effect, and `logic_code` = 3 does not raise `invalid`.
- R10: In select mode, an invalid compare code gives `sel_out` = `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 1 | 0 = predicate mode, 1 = select mode |
| cmp_code | input | 3 | Compare operation code |
| is_signed | input | 1 | 1 = signed compare, 0 = unsigned compare |
| logic_code | input | 2 | Predicate merge operation |
| pred_in | input | 1 | Incoming predicate |
| src_a | input | 32 | First compare operand / first data input |
| src_b | input | 32 | Second compare operand / second data input |
| src_c | input | 32 | Operand tested against zero in select mode |
| pred_out0 | output | 1 | Merged compare outcome |
| pred_out1 | output | 1 | Merged inverted compare outcome |
| sel_out | output | 32 | Selected data word |
| invalid | output | 1 | Unused code flag |

## Verification
The block holds no state, so every wrong internal decision shows at the ports in the same evaluation that causes it.

- A flipped signedness path only shows when operands differ in the top bit. The bench therefore pairs 0x80000000 with 0x7FFFFFFF and tests -1 against zero.
- A mis-decoded compare code shows as a wrong `pred_out0` only for operand orderings where the two relations disagree. For this reason each code is swept over less, equal and greater pairs.
- A mode decoder that leaks shows as a nonzero `sel_out` in predicate mode, or as live predicates in select mode.

// File: rtl/icp_pkg.sv
package icp_pkg;
    typedef enum logic [2:0] {
        CMP_RSV0 = 3'd0,
        CMP_LT   = 3'd1,
        CMP_EQ   = 3'd2,
        CMP_LE   = 3'd3,
        CMP_GT   = 3'd4,
        CMP_NE   = 3'd5,
        CMP_GE   = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'd0,
        LOP_OR  = 2'd1,
        LOP_XOR = 2'd2,
        LOP_RSV = 2'd3
    } lop_e;

    typedef enum logic {
        MODE_PRED = 1'b0,
        MODE_SEL  = 1'b1
    } mode_e;
endpackage

// File: rtl/icp_compare.sv
module icp_compare
    import icp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         is_signed,
    input  cmp_op_e      op,
    output logic         hit,
    output logic         bad_op
);
    logic less;
    logic same;

    always_comb begin
        same = (lhs == rhs);
        if (is_signed) less = ($signed(lhs) < $signed(rhs));
        else           less = (lhs < rhs);
    end

    always_comb begin
        hit    = 1'b0;
        bad_op = 1'b0;
        unique case (op)
            CMP_LT:  hit = less;
            CMP_EQ:  hit = same;
            CMP_LE:  hit = less | same;
            CMP_GT:  hit = ~(less | same);
            CMP_NE:  hit = ~same;
            CMP_GE:  hit = ~less;
            default: bad_op = 1'b1;
        endcase
    end

    // Strict relations never hold on equal operands (R1, R2)
    always_comb begin
        if ((op == CMP_LT || op == CMP_GT) && hit)
            assert_strict_not_equal_R1: assert (lhs != rhs);
        if (bad_op)
            assert_bad_no_hit_R5: assert (!hit);
    end
endmodule

// File: rtl/icp_combine.sv
module icp_combine
    import icp_pkg::*;
(
    input  logic cmp_hit,
    input  logic pred_in,
    input  lop_e lop,
    output logic p_true,
    output logic p_false,
    output logic bad_lop
);
    always_comb begin
        p_true  = 1'b0;
        p_false = 1'b0;
        bad_lop = 1'b0;
        unique case (lop)
            LOP_AND: begin
                p_true  = cmp_hit & pred_in;
                p_false = ~cmp_hit & pred_in;
            end
            LOP_OR: begin
                p_true  = cmp_hit | pred_in;
                p_false = ~cmp_hit | pred_in;
            end
            LOP_XOR: begin
                p_true  = cmp_hit ^ pred_in;
                p_false = ~cmp_hit ^ pred_in;
            end
            default: bad_lop = 1'b1;
        endcase
    end

    always_comb begin
        if (lop == LOP_XOR)
            assert_xor_pair_differs_R4: assert (p_true != p_false);
        if (lop == LOP_OR && pred_in)
            assert_or_pair_high_R3: assert (p_true && p_false);
        if (lop == LOP_AND && !pred_in)
            assert_and_pair_low_R3: assert (!p_true && !p_false);
    end
endmodule

// File: rtl/icp_unit.sv
module icp_unit
    import icp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         mode_sel,
    input  logic [2:0]   cmp_code,
    input  logic         is_signed,
    input  logic [1:0]   logic_code,
    input  logic         pred_in,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] src_c,
    output logic         pred_out0,
    output logic         pred_out1,
    output logic [W-1:0] sel_out,
    output logic         invalid
);
    localparam logic [W-1:0] ZERO = '0;

    mode_e   mode;
    cmp_op_e op;
    lop_e    lop;
    logic    pair_hit, pair_bad;
    logic    zero_hit, zero_bad;
    logic    mrg_true, mrg_false, mrg_bad;

    assign mode = mode_e'(mode_sel);
    assign op   = cmp_op_e'(cmp_code);
    assign lop  = lop_e'(logic_code);

    icp_compare #(.W(W)) u_pair_cmp (
        .lhs(src_a), .rhs(src_b), .is_signed(is_signed), .op(op),
        .hit(pair_hit), .bad_op(pair_bad)
    );

    icp_compare #(.W(W)) u_zero_cmp (
        .lhs(src_c), .rhs(ZERO), .is_signed(is_signed), .op(op),
        .hit(zero_hit), .bad_op(zero_bad)
    );

    icp_combine u_merge (
        .cmp_hit(pair_hit), .pred_in(pred_in), .lop(lop),
        .p_true(mrg_true), .p_false(mrg_false), .bad_lop(mrg_bad)
    );

    always_comb begin
        pred_out0 = 1'b0;
        pred_out1 = 1'b0;
        sel_out   = '0;
        invalid   = 1'b0;
        unique case (mode)
            MODE_PRED: begin
                invalid = pair_bad | mrg_bad;
                if (!(pair_bad | mrg_bad)) begin
                    pred_out0 = mrg_true;
                    pred_out1 = mrg_false;
                end
            end
            MODE_SEL: begin
                invalid = zero_bad;
                sel_out = zero_hit ? src_a : src_b;
            end
            default: invalid = 1'b1;
        endcase
    end

    always_comb begin
        if (mode == MODE_SEL)
            assert_sel_preds_low_R7: assert (!pred_out0 && !pred_out1);
        if (mode == MODE_PRED)
            assert_pred_sel_zero_R9: assert (sel_out == ZERO);
        if (invalid)
            assert_invalid_preds_low_R5: assert (!pred_out0 && !pred_out1);
        if (mode == MODE_SEL && zero_bad)
            assert_sel_invalid_second_R10: assert (sel_out == src_b);
    end
endmodule

// File: tb/icp_unit_test.sv
module icp_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         mode_sel, is_signed, pred_in;
    logic [2:0]   cmp_code;
    logic [1:0]   logic_code;
    logic [W-1:0] src_a, src_b, src_c;
    logic         pred_out0, pred_out1, invalid;
    logic [W-1:0] sel_out;

    icp_unit #(.W(W)) uut (
        .mode_sel(mode_sel), .cmp_code(cmp_code), .is_signed(is_signed),
        .logic_code(logic_code), .pred_in(pred_in),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .pred_out0(pred_out0), .pred_out1(pred_out1),
        .sel_out(sel_out), .invalid(invalid)
    );

    typedef struct packed {
        logic         p0;
        logic         p1;
        logic [W-1:0] sel;
        logic         inv;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    function automatic logic rel(input logic [2:0] code, input logic sgn,
                                 input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] ux, uy;
        ux = sgn ? (x ^ {1'b1, {(W-1){1'b0}}}) : x;
        uy = sgn ? (y ^ {1'b1, {(W-1){1'b0}}}) : y;
        case (code)
            3'd1: return ux <  uy;
            3'd2: return ux == uy;
            3'd3: return ux <= uy;
            3'd4: return ux >  uy;
            3'd5: return ux != uy;
            3'd6: return ux >= uy;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic merge(input logic [1:0] lc, input logic c, input logic p);
        case (lc)
            2'd0: return c & p;
            2'd1: return c | p;
            default: return c ^ p;
        endcase
    endfunction

    function automatic exp_t model(input logic m, input logic [2:0] code, input logic sgn,
                                   input logic [1:0] lc, input logic p,
                                   input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [W-1:0] c);
        exp_t e;
        logic bad_code;
        e = '0;
        bad_code = (code == 3'd0) || (code == 3'd7);
        if (!m) begin
            e.inv = bad_code || (lc == 2'd3);
            if (!e.inv) begin
                e.p0 = merge(lc, rel(code, sgn, a, b), p);
                e.p1 = merge(lc, !rel(code, sgn, a, b), p);
            end
        end else begin
            e.inv = bad_code;
            e.sel = rel(code, sgn, c, '0) ? a : b;
        end
        return e;
    endfunction

    task automatic apply(input logic m, input logic [2:0] code, input logic sgn,
                         input logic [1:0] lc, input logic p,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input string tag);
        @(posedge clk);
        mode_sel = m; cmp_code = code; is_signed = sgn; logic_code = lc;
        pred_in = p; src_a = a; src_b = b; src_c = c;
        exp_q.push_back(model(m, code, sgn, lc, p, a, b, c));
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (pred_out0 !== e.p0 || pred_out1 !== e.p1 || sel_out !== e.sel || invalid !== e.inv) begin
                n_fail++;
                $display("FAIL %s: got p0=%b p1=%b sel=%h inv=%b, expected p0=%b p1=%b sel=%h inv=%b",
                         t, pred_out0, pred_out1, sel_out, invalid, e.p0, e.p1, e.sel, e.inv);
            end
        end
    end

    logic [W-1:0] vals [6] = '{32'd5, 32'd9, 32'hFFFF_FFFD, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0};

    initial begin
        mode_sel = 0; cmp_code = 0; is_signed = 0; logic_code = 0; pred_in = 0;
        src_a = 0; src_b = 0; src_c = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset/idle state: all-zero inputs carry an unused compare code
        apply(0, 3'd0, 0, 2'd0, 0, 0, 0, 0, "R5 idle");

        for (int code = 1; code <= 6; code++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    apply(0, code[2:0], 1, 2'd0, 1, vals[i], vals[j], 0, "R1 signed");
                    apply(0, code[2:0], 0, 2'd0, 1, vals[i], vals[j], 0, "R2 unsigned");
                end
        for (int lc = 0; lc < 3; lc++)
            for (int p = 0; p < 2; p++)
                for (int code = 1; code <= 6; code++) begin
                    apply(0, code[2:0], 1, lc[1:0], p[0], 32'd3, 32'd7, 0, "R3 merge");
                    apply(0, code[2:0], 0, lc[1:0], p[0], 32'd7, 32'd7, 0, "R4 inverted merge");
                end
        apply(0, 3'd0, 1, 2'd1, 1, 1, 2, 0, "R5 code0 pred");
        apply(0, 3'd7, 1, 2'd1, 1, 1, 2, 0, "R5 code7 pred");
        apply(1, 3'd0, 1, 2'd1, 1, 1, 2, 0, "R5 code0 sel");
        apply(1, 3'd7, 0, 2'd0, 0, 1, 2, 5, "R10 invalid sel");
        for (int code = 1; code <= 6; code++)
            apply(0, code[2:0], 1, 2'd3, 1, 4, 4, 0, "R6 logic3");
        for (int code = 1; code <= 6; code++) begin
            apply(1, code[2:0], 1, 2'd0, 0, 32'hAAAA_0001, 32'h5555_0002, 32'hFFFF_FFFF, "R7 select neg");
            apply(1, code[2:0], 1, 2'd1, 1, 32'hAAAA_0001, 32'h5555_0002, 32'd0, "R7 select zero");
            apply(1, code[2:0], 1, 2'd2, 0, 32'hAAAA_0001, 32'h5555_0002, 32'd1, "R7 select pos");
            apply(1, code[2:0], 0, 2'd0, 1, 32'h1234_5678, 32'h8765_4321, 32'hFFFF_FFFF, "R8 select unsigned");
            apply(1, code[2:0], 1, 2'd3, 1, 32'h1, 32'h2, 32'h8000_0000, "R9 logic ignored in select");
        end
        for (int k = 0; k < 300; k++)
            apply($urandom_range(0, 1), 3'($urandom_range(0, 7)), $urandom_range(0, 1),
                  2'($urandom_range(0, 3)), $urandom_range(0, 1),
                  $urandom, $urandom, $urandom, "R3 random");
        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule